// File: doc/BRIEF.md
# Configurable Input Decoder for a Logic Array

This block is the front stage of a programmable logic array. Each input variable is split into a true rail and a complement rail. Every output line forms the AND of those rails that its stored configuration word selects. Configuration sets how the variables are grouped into partitions, the order of the output lines, and which spare lines stand in for faulty ones. The physical wiring does not fix any of these.

The output lines drive a downstream AND plane. Configuration is written one line at a time through a simple write port. The same block can also be configured as a full minterm decoder, which is the address decoder of a conventional random-access memory. The line outputs are registered.

Top module: `arr_decoder`

## Requirements
- R1: A synchronous active-high reset clears every configuration word and drives all output lines to 0.
- R2: Each variable i feeds a true rail equal to vars_i[i] and a complement rail equal to its inverse. Configuration word bit i enables the true rail of variable i, and bit N_VARS+i enables its complement rail.
- R3: Output line k is registered. It equals the AND of every rail enabled in word k, evaluated on the inputs and configuration present before the clock edge, and it changes only at that edge.
- R4: A line whose word enables no rail stays 0 for every input value.
- R5: A line that enables both rails of the same variable stays 0 for every input value.
- R6: Word bit 2*N_VARS is a disable flag. A disabled line stays 0 whatever rails it enables.
- R7: When lines are configured as a 2-variable group (variables 0 and 1, lines 0..3) plus a 1-variable group (variable 2, lines 4..5), exactly one line of each group is high for every input value.
- R8: Rewriting the configuration words of two lines swaps which input codes raise them. No other line changes.
- R9: A spare line configured with the same rails as a disabled line takes over its function.
- R10: With line k enabling the true rail of each variable whose bit is set in k and the complement rail of every other variable, the outputs are one-hot at position vars_i. This is a full address decode.
- R11: A configuration write takes effect on the output at the first clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vars_i | input | N_VARS | Input variables |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_line_i | input | LINE_AW | Index of the line being written |
| cfg_word_i | input | 2*N_VARS+1 | Configuration word: true enables, complement enables, disable flag |
| lines_o | output | N_LINES | Registered decoder lines to the AND plane |

## Verification
Every line result is due at the first rising edge after the variables change. The bench applies inputs on a falling edge and samples on the next falling edge. It also reads the lines once just before that rising edge, to confirm they still hold the previous result. A configuration write lands at its own rising edge and shows up in the output at the edge after that. For this reason every sweep starts with a fresh input application after the write has finished. Expected line vectors are derived arithmetically from the input code and the group layout, for the partitioned, permuted, spare and full-decode arrangements.

// File: rtl/arr_decoder_pkg.sv
package arr_decoder_pkg;
  localparam int unsigned VARS_DEFAULT  = 3;
  localparam int unsigned LINES_DEFAULT = 8;

  function automatic int unsigned word_width(input int unsigned n_vars);
    return 2 * n_vars + 1;
  endfunction
endpackage

// File: rtl/dec_rails.sv
module dec_rails #(
  parameter int unsigned N_VARS = 3
) (
  input  logic [N_VARS-1:0] vars_i,
  output logic [N_VARS-1:0] true_o,
  output logic [N_VARS-1:0] comp_o
);
  always_comb begin
    true_o = vars_i;
    comp_o = ~vars_i;
  end
endmodule

// File: rtl/dec_pers.sv
module dec_pers #(
  parameter int unsigned N_VARS  = 3,
  parameter int unsigned N_LINES = 8,
  localparam int unsigned CW = 2 * N_VARS + 1,
  localparam int unsigned AW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [CW-1:0]         word_i,
  output logic [N_LINES*CW-1:0] flat_o
);
  logic [CW-1:0] store_q [N_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINES; i++) store_q[i] <= '0;
    end else if (we_i && (32'(addr_i) < N_LINES)) begin
      store_q[addr_i] <= word_i;
    end
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_flat
    assign flat_o[g*CW +: CW] = store_q[g];
  end
endmodule

// File: rtl/dec_term.sv
module dec_term #(
  parameter int unsigned N_VARS = 3,
  localparam int unsigned CW = 2 * N_VARS + 1
) (
  input  logic [N_VARS-1:0] true_i,
  input  logic [N_VARS-1:0] comp_i,
  input  logic [CW-1:0]     word_i,
  output logic              hit_o
);
  logic [N_VARS-1:0] en_t, en_c;
  logic              off, none;

  always_comb begin
    en_t  = word_i[N_VARS-1:0];
    en_c  = word_i[2*N_VARS-1:N_VARS];
    off   = word_i[2*N_VARS];
    none  = ~|word_i[2*N_VARS-1:0];
    hit_o = ~off & ~none & (&(true_i | ~en_t)) & (&(comp_i | ~en_c));
  end
endmodule

// File: rtl/arr_decoder.sv
module arr_decoder
  import arr_decoder_pkg::*;
#(
  parameter int unsigned N_VARS  = VARS_DEFAULT,
  parameter int unsigned N_LINES = LINES_DEFAULT,
  localparam int unsigned CW      = 2 * N_VARS + 1,
  localparam int unsigned LINE_AW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_VARS-1:0]  vars_i,
  input  logic               cfg_we_i,
  input  logic [LINE_AW-1:0] cfg_line_i,
  input  logic [CW-1:0]      cfg_word_i,
  output logic [N_LINES-1:0] lines_o
);
  logic [N_VARS-1:0]     rail_t, rail_c;
  logic [N_LINES*CW-1:0] pers_flat;
  logic [N_LINES-1:0]    hit;

  dec_rails #(.N_VARS(N_VARS)) u_rails (
    .vars_i (vars_i),
    .true_o (rail_t),
    .comp_o (rail_c)
  );

  dec_pers #(.N_VARS(N_VARS), .N_LINES(N_LINES)) u_pers (
    .clk    (clk),
    .rst    (rst),
    .we_i   (cfg_we_i),
    .addr_i (cfg_line_i),
    .word_i (cfg_word_i),
    .flat_o (pers_flat)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    dec_term #(.N_VARS(N_VARS)) u_term (
      .true_i (rail_t),
      .comp_i (rail_c),
      .word_i (pers_flat[g*CW +: CW]),
      .hit_o  (hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lines_o <= '0;
    else     lines_o <= hit;
  end
endmodule

// File: rtl/arr_decoder_chk.sv
module arr_decoder_chk #(
  parameter int unsigned N_VARS  = 3,
  parameter int unsigned N_LINES = 8,
  localparam int unsigned CW = 2 * N_VARS + 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_VARS-1:0]     vars_i,
  input logic [N_LINES*CW-1:0] pers_flat,
  input logic [N_LINES-1:0]    lines_o
);
  logic [N_LINES-1:0] dis_v, empty_v, clash_v;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      dis_v[i]   = pers_flat[i*CW + 2*N_VARS];
      empty_v[i] = ~|pers_flat[i*CW +: 2*N_VARS];
      clash_v[i] = |(pers_flat[i*CW +: N_VARS] & pers_flat[i*CW + N_VARS +: N_VARS]);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (lines_o == '0)); // R1

  AST_STABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(vars_i) && $stable(pers_flat)) |=> $stable(lines_o)); // R3

  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((lines_o & $past(empty_v)) == '0)); // R4

  AST_CLASH_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((lines_o & $past(clash_v)) == '0)); // R5

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((lines_o & $past(dis_v)) == '0)); // R6
endmodule

bind arr_decoder arr_decoder_chk #(.N_VARS(N_VARS), .N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .vars_i    (vars_i),
  .pers_flat (pers_flat),
  .lines_o   (lines_o)
);

// File: tb/test_arr_decoder.sv
`timescale 1ns/1ps
module test_arr_decoder;
  localparam int NV = 3;
  localparam int NL = 8;
  localparam int CW = 2 * NV + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NV-1:0] vars_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_line_i = '0;
  logic [CW-1:0] cfg_word_i = '0;
  logic [NL-1:0] lines_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  arr_decoder #(.N_VARS(NV), .N_LINES(NL)) i_arr_decoder (
    .clk(clk), .rst(rst), .vars_i(vars_i), .cfg_we_i(cfg_we_i),
    .cfg_line_i(cfg_line_i), .cfg_word_i(cfg_word_i), .lines_o(lines_o)
  );

  task automatic check(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lines actual %b expected %b", req, act, exp);
    end
  endtask

  // word layout: [2:0] true enables, [5:3] complement enables, [6] disable
  task automatic wcfg(input int line, input bit dis, input logic [2:0] cmp, input logic [2:0] tru);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_line_i = 3'(line); cfg_word_i = {dis, cmp, tru};
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic apply(input logic [2:0] v);
    @(negedge clk);
    vars_i = v;
    @(negedge clk);
  endtask

  function automatic logic [NL-1:0] bit_at(input int k);
    return NL'(1) << k;
  endfunction

  task automatic prog_partition();
    for (int k = 0; k < 4; k++) wcfg(k, 1'b0, {1'b0, ~2'(k)}, {1'b0, 2'(k)});
    wcfg(4, 1'b0, 3'b100, 3'b000);
    wcfg(5, 1'b0, 3'b000, 3'b100);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", lines_o, '0);
    rst = 1'b0;
    apply(3'b101);
    check("R1 cleared personality", lines_o, '0);

    // R7 standard 2+1 partition
    prog_partition();
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      check("R7 partition", lines_o, bit_at(v & 3) | bit_at(4 + (v >> 2)));
      check("R7 one per group", NL'($countones(lines_o[3:0]) == 1 && $countones(lines_o[5:4]) == 1), NL'(1));
    end

    // R3 timing: value holds until the next edge
    apply(3'b000);
    @(negedge clk); vars_i = 3'b011; #1;
    check("R3 hold before edge", lines_o, bit_at(0) | bit_at(4));
    @(negedge clk);
    check("R3 after edge", lines_o, bit_at(3) | bit_at(4));

    // R11 config write visible one edge after write edge
    @(negedge clk); cfg_we_i = 1'b1; cfg_line_i = 3'd7; cfg_word_i = {1'b0, 3'b000, 3'b010};
    @(negedge clk); cfg_we_i = 1'b0;
    check("R11 not yet", lines_o, bit_at(3) | bit_at(4));
    @(negedge clk);
    check("R11 applied", lines_o, bit_at(3) | bit_at(4) | bit_at(7));

    // R2 single true rail / single complement rail on line 7
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      check("R2 true rail", NL'(lines_o[7]), NL'((v >> 1) & 1));
    end
    wcfg(7, 1'b0, 3'b010, 3'b000);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      check("R2 complement rail", NL'(lines_o[7]), NL'(((v >> 1) & 1) ^ 1));
    end

    // R5 both rails of variable 0
    wcfg(7, 1'b0, 3'b001, 3'b001);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      check("R5 inhibit", NL'(lines_o[7]), '0);
    end

    // R4 empty line
    wcfg(7, 1'b0, 3'b000, 3'b000);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      check("R4 empty", NL'(lines_o[7]), '0);
    end

    // R8 swap lines 0 and 3
    wcfg(0, 1'b0, 3'b000, 3'b011);
    wcfg(3, 1'b0, 3'b011, 3'b000);
    for (int v = 0; v < 8; v++) begin
      int ab;
      ab = v & 3;
      ab = (ab == 0) ? 3 : (ab == 3) ? 0 : ab;
      apply(3'(v));
      check("R8 permuted", lines_o, bit_at(ab) | bit_at(4 + (v >> 2)));
    end

    // R6 disable line 5, R9 spare line 6 takes over
    wcfg(5, 1'b1, 3'b000, 3'b100);
    for (int v = 4; v < 8; v++) begin
      apply(3'(v));
      check("R6 disabled", NL'(lines_o[5]), '0);
    end
    wcfg(6, 1'b0, 3'b000, 3'b100);
    prog_partition();
    wcfg(5, 1'b1, 3'b000, 3'b100);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      check("R9 spare", lines_o, bit_at(v & 3) | ((v >> 2) != 0 ? bit_at(6) : bit_at(4)));
    end

    // R10 full address decode
    for (int k = 0; k < 8; k++) wcfg(k, 1'b0, ~3'(k), 3'(k));
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      check("R10 full decode", lines_o, bit_at(v));
    end

    // R1 reset after configuration
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    apply(3'b010);
    check("R1 reset clears", lines_o, '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule